// File: doc/BRIEF.md
# Extended-Precision Float to Signed Integer Converter

This block turns a 128-bit extended-precision floating-point value into a signed integer. The integer can be 8, 16 or 32 bits wide, and the 32-bit case can either truncate toward zero or round to nearest. A two-bit mode input selects the width and the rounding. The result is always presented sign-extended to 32 bits. Two flags come with it: an integer-overflow flag and a reserved-operand fault.

The operand layout is as follows:
- bit 127 holds the sign.
- bits 126:112 hold a 15-bit biased exponent with bias 16384.
- bits 111:0 hold the fraction below a hidden leading one.

A nonzero exponent E therefore encodes the value 0.1fff (binary) times 2^(E-16384).

The block takes one operand per cycle when `in_valid` is high. It presents the registered result one cycle later, with `out_valid` high. When a value does not fit the selected width, the block reports the wrapped low-order bits of the result. It does not saturate.

Top module: `hfloat_to_int`

## Requirements
- R1: Each operand accepted with `in_valid` high produces its outputs on the next clock edge, with `out_valid` high. While `in_valid` is low, `out_valid` goes low and `result`, `int_ovf` and `rsvd_fault` hold their values.
- R2: A biased exponent below 16384 (a magnitude below one half, or a zero) gives result 0 and no overflow. The exponent-0, sign-1 pattern is excluded; see R3.
- R3: Exponent field 0 with sign 1 is reserved. It raises `rsvd_fault` with result 0 and no overflow. Every other operand leaves `rsvd_fault` low.
- R4: Modes 0 (byte), 1 (word) and 2 (longword) truncate the magnitude toward zero.
- R5: Mode 3 (rounded longword) rounds the magnitude to nearest, and a tie goes away from zero. For example, 2.5 gives 3 and -2.5 gives -3.
- R6: For an unbiased exponent of 127 or less, overflow is flagged when the magnitude exceeds 127, 32767 or 2147483647 for the byte, word or longword widths. For negative values each bound is one larger.
- R7: A magnitude of 2^32 or more with an unbiased exponent of 127 or less flags overflow. The result keeps the low 32 bits of the magnitude.
- R8: An unbiased exponent from 128 to 159 always flags overflow. The result is then built from the low 32 bits of the magnitude.
- R9: An unbiased exponent above 159 gives result 0 with overflow flagged.
- R10: A negative source yields the two's complement of the low 32 magnitude bits. That value is truncated to the selected width and sign-extended to 32 bits.
- R11: After reset, `out_valid`, `result`, `int_ovf` and `rsvd_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and mode are valid this cycle |
| operand | input | 128 | Packed source: sign, biased exponent, fraction |
| mode | input | 2 | 0 byte, 1 word, 2 longword truncated, 3 longword rounded |
| out_valid | output | 1 | Result registered from the previous valid input |
| result | output | 32 | Signed integer, sign-extended to 32 bits |
| int_ovf | output | 1 | Integer overflow |
| rsvd_fault | output | 1 | Reserved-operand fault |

## Verification
The block has no parameters, so the bench builds its only configuration. Random exponents are drawn from several bands that each reach a different path:
- just below one half;
- the small-integer range around each width bound;
- the wrapped band from 128 to 159;
- beyond 159.

Directed operands pin down the signed bounds of each width, the round-half cases, and the edges of both the exponent-128 and exponent-160 transitions.

// File: rtl/hfloat_to_int.sv
module hfloat_to_int (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] operand,
  input  logic [1:0]   mode,
  output logic         out_valid,
  output logic [31:0]  result,
  output logic         int_ovf,
  output logic         rsvd_fault
);
  localparam logic [14:0] BIAS     = 15'd16384;
  localparam logic [14:0] TOP_MID  = BIAS + 15'd127;
  localparam logic [14:0] TOP_WRAP = BIAS + 15'd159;

  logic         sgn;
  logic [14:0]  bexp;
  logic [127:0] mant;
  logic         below, mid, wrap_ok;
  logic [6:0]   rsh;
  logic [127:0] sh1, sh2, mid_mag;
  logic [31:0]  big_mag, mag, sv, res_n;
  logic [32:0]  limit;
  logic         mid_ovf, ovf_n, fault_n;

  assign sgn     = operand[127];
  assign bexp    = operand[126:112];
  assign mant    = {1'b1, operand[111:0], 15'd0};
  assign below   = bexp < BIAS;
  assign mid     = !below && (bexp <= TOP_MID);
  assign wrap_ok = bexp <= TOP_WRAP;

  // right shift keeps one rounding bit below the integer
  assign rsh     = ~bexp[6:0];
  assign sh1     = mant >> rsh;
  assign sh2     = sh1 + {127'd0, mode == 2'd3};
  assign mid_mag = sh2 >> 1;

  // wrapped band: only the low 32 bits survive a left shift
  assign big_mag = mant[31:0] << bexp[4:0];

  always_comb begin
    case (mode)
      2'd0:    limit = 33'h0_0000_007F;
      2'd1:    limit = 33'h0_0000_7FFF;
      default: limit = 33'h0_7FFF_FFFF;
    endcase
    limit = limit + {32'd0, sgn};
  end

  assign mid_ovf = (|mid_mag[127:32]) || ({1'b0, mid_mag[31:0]} > limit);

  always_comb begin
    if (below) begin
      mag = 32'd0; ovf_n = 1'b0;
    end else if (mid) begin
      mag = mid_mag[31:0]; ovf_n = mid_ovf;
    end else begin
      mag = wrap_ok ? big_mag : 32'd0; ovf_n = 1'b1;
    end
  end

  assign sv = sgn ? (32'd0 - mag) : mag;

  always_comb begin
    case (mode)
      2'd0:    res_n = {{24{sv[7]}}, sv[7:0]};
      2'd1:    res_n = {{16{sv[15]}}, sv[15:0]};
      default: res_n = sv;
    endcase
  end

  assign fault_n = (bexp == 15'd0) && sgn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= 32'd0;
      int_ovf    <= 1'b0;
      rsvd_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_n;
        int_ovf    <= ovf_n;
        rsvd_fault <= fault_n;
      end
    end
  end
endmodule

// File: rtl/hfloat_to_int_chk.sv
module hfloat_to_int_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [127:0] operand,
  input logic [1:0]   mode,
  input logic         out_valid,
  input logic [31:0]  result,
  input logic         int_ovf,
  input logic         rsvd_fault
);
  logic [14:0] e;
  logic        rsv;
  assign e   = operand[126:112];
  assign rsv = (e == 15'd0) && operand[127];

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(int_ovf) && $stable(rsvd_fault));
  assert_small_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && e < 15'd16384 && !rsv |=> result == 32'd0 && !int_ovf && !rsvd_fault);
  assert_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rsv |=> rsvd_fault && result == 32'd0 && !int_ovf);
  assert_nofault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !rsv |=> !rsvd_fault);
  assert_wrap_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && e > 15'd16511 |=> int_ovf);
  assert_huge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && e > 15'd16543 |=> result == 32'd0 && int_ovf);
  assert_byte_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == 2'd0 |=> (result[31:7] == 25'd0) || (&result[31:7]));
  assert_word_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == 2'd1 |=> (result[31:15] == 17'd0) || (&result[31:15]));
endmodule

bind hfloat_to_int hfloat_to_int_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand), .mode(mode),
  .out_valid(out_valid), .result(result), .int_ovf(int_ovf), .rsvd_fault(rsvd_fault)
);

// File: tb/hfloat_to_int_test.sv
`timescale 1ns/1ps
module hfloat_to_int_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] operand = '0;
  logic [1:0]   mode = 2'd0;
  logic         out_valid;
  logic [31:0]  result;
  logic         int_ovf;
  logic         rsvd_fault;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hfloat_to_int uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand), .mode(mode),
    .out_valid(out_valid), .result(result), .int_ovf(int_ovf), .rsvd_fault(rsvd_fault)
  );

  // reference: value = S * 2^(ue-113), S = {1, fraction}
  function automatic logic [33:0] model(logic [127:0] op, logic [1:0] md);
    int ue;
    logic [191:0] s, mag;
    logic sg, ovf;
    logic [31:0] lo, v;
    logic [32:0] lim;
    sg = op[127];
    ue = int'(op[126:112]) - 16384;
    if (op[126:112] == 15'd0 && sg) return {1'b1, 1'b0, 32'd0};
    if (ue < 0) return 34'd0;
    if (ue > 159) return {1'b0, 1'b1, 32'd0};
    s = {79'd0, 1'b1, op[111:0]};
    if (ue >= 113) mag = s << (ue - 113);
    else begin
      mag = s >> (113 - ue);
      if (md == 2'd3 && s[112 - ue]) mag = mag + 192'd1;
    end
    lim = (md == 2'd0) ? 33'd127 : (md == 2'd1) ? 33'd32767 : 33'h7FFFFFFF;
    lim = lim + {32'd0, sg};
    ovf = (ue > 127) || (mag > {159'd0, lim});
    lo = mag[31:0];
    v = sg ? (32'd0 - lo) : lo;
    if (md == 2'd0) v = {{24{v[7]}}, v[7:0]};
    else if (md == 2'd1) v = {{16{v[15]}}, v[15:0]};
    return {1'b0, ovf, v};
  endfunction

  // float from integer n (nonzero) scaled by 2^eadj
  function automatic logic [127:0] mkf(logic sg, logic [63:0] n, int eadj);
    int p;
    logic [175:0] t;
    p = 0;
    for (int i = 0; i < 64; i++) if (n[i]) p = i;
    t = {112'd0, n} << (112 - p);
    return {sg, 15'(16384 + p + 1 + eadj), t[111:0]};
  endfunction

  task automatic apply(logic [127:0] op, logic [1:0] md, string tag);
    logic [33:0] exp;
    @(negedge clk);
    in_valid = 1'b1; operand = op; mode = md;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(op, md);
    total++;
    if (!out_valid || result !== exp[31:0] || int_ovf !== exp[32] || rsvd_fault !== exp[33]) begin
      bad++;
      $display("FAIL %s op=%h mode=%0d: got v=%0b r=%h o=%0b f=%0b exp r=%h o=%0b f=%0b",
               tag, op, md, out_valid, result, int_ovf, rsvd_fault, exp[31:0], exp[32], exp[33]);
    end
  endtask

  function automatic logic [127:0] rnd_op();
    logic [14:0] e;
    int b;
    b = int'($urandom_range(0, 5));
    case (b)
      0: e = 15'($urandom_range(16370, 16383));
      1: e = 15'($urandom_range(16384, 16420));
      2: e = 15'($urandom_range(16470, 16511));
      3: e = 15'($urandom_range(16512, 16543));
      4: e = 15'($urandom_range(16540, 16560));
      default: e = 15'($urandom);
    endcase
    return {1'($urandom), e, $urandom, $urandom, $urandom, 16'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== 32'd0 || int_ovf !== 1'b0 || rsvd_fault !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset: v=%0b r=%h o=%0b f=%0b exp all 0", out_valid, result, int_ovf, rsvd_fault);
    end
    rst_n = 1'b1;

    apply(128'd0, 2'd2, "R2 zero");
    apply(mkf(1'b0, 64'd1, -1), 2'd2, "R2 R4 half trunc");
    apply(mkf(1'b0, 64'd1, -2), 2'd3, "R2 quarter");
    apply({1'b1, 15'd0, 112'h1234}, 2'd0, "R3 reserved");
    apply({1'b0, 15'd0, 112'h55}, 2'd1, "R2 R3 dirty zero");
    apply(mkf(1'b0, 64'd127, 0), 2'd0, "R6 byte max");
    apply(mkf(1'b0, 64'd128, 0), 2'd0, "R6 byte over");
    apply(mkf(1'b1, 64'd128, 0), 2'd0, "R6 R10 byte min");
    apply(mkf(1'b1, 64'd129, 0), 2'd0, "R6 R10 byte under");
    apply(mkf(1'b0, 64'd32767, 0), 2'd1, "R6 word max");
    apply(mkf(1'b0, 64'd32768, 0), 2'd1, "R6 word over");
    apply(mkf(1'b1, 64'd32768, 0), 2'd1, "R6 word min");
    apply(mkf(1'b0, 64'h7FFFFFFF, 0), 2'd2, "R6 long max");
    apply(mkf(1'b0, 64'h80000000, 0), 2'd2, "R6 long over");
    apply(mkf(1'b1, 64'h80000000, 0), 2'd2, "R6 R10 long min");
    apply(mkf(1'b0, 64'd5, -1), 2'd2, "R4 2.5 trunc");
    apply(mkf(1'b0, 64'd5, -1), 2'd3, "R5 2.5 round");
    apply(mkf(1'b1, 64'd5, -1), 2'd3, "R5 -2.5 round");
    apply(mkf(1'b0, 64'd1, -1), 2'd3, "R5 half round");
    apply(mkf(1'b0, 64'd9, -2), 2'd3, "R5 2.25 round");
    apply(mkf(1'b0, 64'hFFFFFFFF, -1), 2'd3, "R5 R6 round to bound");
    apply(mkf(1'b0, 64'h10000000005, 0), 2'd2, "R7 wide");
    apply(mkf(1'b1, 64'h10000000005, 0), 2'd0, "R7 R10 wide neg byte");
    apply({1'b0, 15'd16511, 112'hABCDEF}, 2'd2, "R7 ue127");
    apply({1'b0, 15'd16512, 112'h0123456789}, 2'd2, "R8 ue128");
    apply({1'b1, 15'd16543, 112'h0123456789ABCDEF}, 2'd2, "R8 R10 ue159");
    apply({1'b0, 15'd16544, 112'hFFFF}, 2'd2, "R9 ue160");
    apply({1'b1, 15'h7FFF, 112'd7}, 2'd1, "R9 max exp");

    @(negedge clk);
    operand = {1'b0, 15'd16390, 112'd99}; mode = 2'd0;
    begin
      logic [31:0] r0;
      r0 = result;
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0 || result !== r0) begin
        bad++;
        $display("FAIL R1 hold: v=%0b r=%h exp v=0 r=%h", out_valid, result, r0);
      end
    end

    for (int k = 0; k < 3000; k++)
      apply(rnd_op(), 2'($urandom), "R4 R5 R6 R8 R10 random");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule